// File: doc/BRIEF.md
# SPI Serial Clock Prescaler and Edge Selector

This block derives the SPI serial clock (SCK) from the peripheral clock. The division ratio is set by a coded 16-bit scale word. The low three bits pick a power-of-two ratio, or a bypass code. A five-bit prescale field adds a further divide-by-32 when it holds all ones. The transmit and receive sides each have their own scale word and their own divider. The transmit divider drives SCK and the launch strobe. The receive divider drives the sample strobe. Software normally loads both words with the same value, and the two dividers then run in lockstep.

SCK rests at the level given by the polarity input whenever the block is not running. The polarity and phase inputs choose which SCK direction launches data and which one samples it. The shift engine consumes two one-cycle strobes: `launch_o` and `sample_o`. Each strobe is high in the cycle in which SCK, or the receive-side clock, first shows its new level.

Top module: `spi_sck_gen`

## Requirements
- R1: While `run_i` is low, and from one cycle after it falls, `sck_o` equals `cpol_i` and both strobes are low. After reset with `run_i` low, `sck_o` equals `cpol_i`.
- R2: Scale bits [2:0] set the ratio when bits [12:8] are not 5'h1F. Codes 0, 1, 2, 3 and 4 give SCK periods of 2, 4, 8, 16 and 32 peripheral cycles.
- R3: Bits [12:8] equal to 5'h1F multiply the ratio by 32. Codes 0 to 4 then give periods of 64, 128, 256, 512 and 1024 cycles.
- R4: Scale bits [2:0] = 7 with no prescale is the bypass mode. SCK changes level on every cycle, and both `launch_o` and `sample_o` are high on every running cycle.
- R5: For every ratio of 2 or more, SCK stays high for exactly half the period and low for exactly half the period.
- R6: The edge select is `cpol_i ^ ~cpha_i`. When it is 1, launch strobes mark falling SCK edges and sample strobes mark rising edges. When it is 0, launch marks rising edges and sample marks falling edges. Each strobe coincides with the first cycle of the new level.
- R7: The receive scale word alone sets the sample-strobe spacing. Sample strobes are one receive period apart, or one cycle apart in bypass.
- R8: A scale change made while running is picked up only when SCK returns to its idle level. A change made during the non-idle half takes effect after that half. A change made during the idle half waits one more full period.
- R9: Codes 5 and 6 act as code 4. Code 7 together with the prescale field gives a ratio of 32. Any prescale value other than 5'h1F means no prescale. Bits other than [12:8] and [2:0] are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Clock enable; low holds SCK idle |
| cpol_i | input | 1 | Clock polarity, which is also the idle level |
| cpha_i | input | 1 | Clock phase |
| tx_scale_i | input | 16 | Coded transmit scale word |
| rx_scale_i | input | 16 | Coded receive scale word |
| sck_o | output | 1 | Serial clock |
| launch_o | output | 1 | One-cycle strobe at each launch edge |
| sample_o | output | 1 | One-cycle strobe at each sample edge |

## Verification
The assertions check several properties on every cycle inside each divider:
- a stopped divider returns to idle with no strobe;
- every strobe comes with a change of level;
- the divide counter never passes its latched span;
- the latched span stays fixed through the non-idle half of each period.

The exact periods for every code, with and without prescale, can only be shown by the bench's sweeps over all four clock modes. The same holds for the 50% duty cycle, the strobe directions, the independent receive spacing, the reserved-code handling and the two timings of a scale change made while running.

// File: rtl/spi_sck_pkg.sv
package spi_sck_pkg;
    localparam int SCALE_W    = 16;
    localparam int LOW_LSB    = 0;
    localparam int LOW_W      = 3;
    localparam int PRE_LSB    = 8;
    localparam int PRE_W      = 5;
    localparam logic [PRE_W-1:0] PRE_MATCH  = 5'h1F;
    localparam logic [LOW_W-1:0] BYPASS_LOW = 3'd7;

    // Which SCK direction carries the launch strobe
    typedef enum logic {
        ARR_LAUNCH_RISE = 1'b0,
        ARR_LAUNCH_FALL = 1'b1
    } edge_arr_e;
endpackage

// File: rtl/spi_scale_decode.sv
module spi_scale_decode
    import spi_sck_pkg::*;
#(
    parameter int CODE_MAX = 4,
    parameter int PRE_LOG  = 5,
    parameter int CNT_W    = CODE_MAX + PRE_LOG
) (
    input  logic [SCALE_W-1:0] scale_i,
    output logic [CNT_W-1:0]   span_m1_o,
    output logic               bypass_o
);
    logic [LOW_W-1:0] low;
    logic             pre;
    int               lg_low;
    int               lg;
    int               sh;

    always_comb begin
        low = scale_i[LOW_LSB +: LOW_W];
        pre = (scale_i[PRE_LSB +: PRE_W] == PRE_MATCH);
        if (low == BYPASS_LOW)
            lg_low = 0;
        else if (int'(low) > CODE_MAX)
            lg_low = CODE_MAX + 1;
        else
            lg_low = int'(low) + 1;
        lg        = lg_low + (pre ? PRE_LOG : 0);
        bypass_o  = (lg == 0);
        sh        = (lg == 0) ? 0 : lg - 1;
        span_m1_o = CNT_W'((1 << sh) - 1);
    end
endmodule

// File: rtl/spi_edge_timer.sv
module spi_edge_timer #(
    parameter int CNT_W = 9
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic [CNT_W-1:0] span_m1_i,
    input  logic             bypass_i,
    output logic             act_o,
    output logic             stb_o,
    output logic             bypass_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] span;
        logic             byp;
        logic             act;
        logic             stb;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.stb = 1'b0;
        if (!run_i) begin
            st_d.cnt  = '0;
            st_d.act  = 1'b0;
            st_d.span = span_m1_i;
            st_d.byp  = bypass_i;
        end else if (st_q.cnt == st_q.span) begin
            st_d.cnt = '0;
            st_d.act = ~st_q.act;
            st_d.stb = 1'b1;
            if (st_q.act) begin
                // returning to idle level: pick up a new ratio here only
                st_d.span = span_m1_i;
                st_d.byp  = bypass_i;
            end
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign act_o    = st_q.act;
    assign stb_o    = st_q.stb;
    assign bypass_o = st_q.byp;

    logic             act_q, stb_q;
    logic [CNT_W-1:0] cnt_q, span_q;
    assign act_q  = st_q.act;
    assign stb_q  = st_q.stb;
    assign cnt_q  = st_q.cnt;
    assign span_q = st_q.span;

    p_stop_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_i |=> (!act_q && !stb_q));

    p_stb_toggle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stb_q |-> (act_q != $past(act_q)));

    p_cnt_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q <= span_q);

    p_span_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (act_q && $past(act_q)) |-> $stable(span_q));
endmodule

// File: rtl/spi_sck_gen.sv
module spi_sck_gen
    import spi_sck_pkg::*;
#(
    parameter int CODE_MAX = 4,
    parameter int PRE_LOG  = 5,
    localparam int CNT_W   = CODE_MAX + PRE_LOG
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               run_i,
    input  logic               cpol_i,
    input  logic               cpha_i,
    input  logic [SCALE_W-1:0] tx_scale_i,
    input  logic [SCALE_W-1:0] rx_scale_i,
    output logic               sck_o,
    output logic               launch_o,
    output logic               sample_o
);
    localparam int N_PATH = 2; // 0: transmit, 1: receive

    logic [N_PATH-1:0] act, stb, byp, dec_byp;
    logic [CNT_W-1:0]  dec_span [N_PATH];

    for (genvar g = 0; g < N_PATH; g++) begin : g_path
        spi_scale_decode #(
            .CODE_MAX (CODE_MAX),
            .PRE_LOG  (PRE_LOG),
            .CNT_W    (CNT_W)
        ) u_dec (
            .scale_i   ((g == 0) ? tx_scale_i : rx_scale_i),
            .span_m1_o (dec_span[g]),
            .bypass_o  (dec_byp[g])
        );

        spi_edge_timer #(
            .CNT_W (CNT_W)
        ) u_tmr (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .run_i     (run_i),
            .span_m1_i (dec_span[g]),
            .bypass_i  (dec_byp[g]),
            .act_o     (act[g]),
            .stb_o     (stb[g]),
            .bypass_o  (byp[g])
        );
    end

    edge_arr_e arr;
    logic      rx_lvl;
    logic      launch_lvl;

    always_comb begin
        arr        = (cpol_i ^ ~cpha_i) ? ARR_LAUNCH_FALL : ARR_LAUNCH_RISE;
        launch_lvl = (arr == ARR_LAUNCH_RISE);
        sck_o      = cpol_i ^ act[0];
        rx_lvl     = cpol_i ^ act[1];
        launch_o   = run_i && stb[0] && (byp[0] || (sck_o == launch_lvl));
        sample_o   = run_i && stb[1] && (byp[1] || (rx_lvl == ~launch_lvl));
    end
endmodule

// File: tb/spi_sck_gen_tb.sv
module spi_sck_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic        cpol = 1'b1;
    logic        cpha = 1'b0;
    logic [15:0] tx_scale = 16'h0000;
    logic [15:0] rx_scale = 16'h0000;
    logic        sck, launch, sample;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk; // 250 MHz

    spi_sck_gen u_dut (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .run_i      (run),
        .cpol_i     (cpol),
        .cpha_i     (cpha),
        .tx_scale_i (tx_scale),
        .rx_scale_i (rx_scale),
        .sck_o      (sck),
        .launch_o   (launch),
        .sample_o   (sample)
    );

    task automatic chk(input bit ok, input string req, input int actual, input int expected);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    // Runs a configuration for nper transmit periods and checks the
    // edge spacing, duty, strobe directions and receive strobe spacing.
    task automatic run_case(input logic [15:0] stx, input logic [15:0] srx,
                            input bit pol, input bit pha,
                            input int ntx, input int nrx, input int nper,
                            input string tag);
        bit sel, prev, tog, exp_l, exp_s;
        int htx, last_t, last_s, span_s, ncyc;
        run = 1'b0; tx_scale = stx; rx_scale = srx; cpol = pol; cpha = pha;
        repeat (3) @(negedge clk);
        chk(sck == pol && !launch && !sample, "R1", int'(sck), int'(pol));
        sel    = pol ^ ~pha;
        htx    = (ntx >= 2) ? ntx / 2 : 1;
        span_s = (nrx >= 2) ? nrx : 1;
        ncyc   = nper * ((ntx >= 2) ? ntx : 2) + 4;
        run = 1'b1; prev = sck; last_t = -1; last_s = -1;
        for (int c = 0; c < ncyc; c++) begin
            @(negedge clk);
            tog = (sck != prev);
            if (tog) begin
                if (last_t >= 0) chk(c - last_t == htx, {tag, "/R5"}, c - last_t, htx);
                last_t = c;
            end
            exp_l = (ntx == 1) ? 1'b1 : (tog && (sck == ~sel));
            chk(launch == exp_l, (ntx == 1) ? "R4" : "R6", int'(launch), int'(exp_l));
            if (srx == stx) begin
                exp_s = (ntx == 1) ? 1'b1 : (tog && (sck == sel));
                chk(sample == exp_s, (ntx == 1) ? "R4" : "R6", int'(sample), int'(exp_s));
            end
            if (sample) begin
                if (last_s >= 0) chk(c - last_s == span_s, "R7", c - last_s, span_s);
                last_s = c;
            end
            prev = sck;
        end
        chk(last_t >= 0, tag, last_t, 0);
        run = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(sck == pol && !launch && !sample, "R1", int'(sck), int'(pol));
    endtask

    // Ratio 8 switched to ratio 4 right after a rising or a falling SCK edge
    task automatic change_case(input bit after_rise);
        int exp_iv [3];
        int iv_n, last_t, c, seen_fall;
        bit prev, armed;
        run = 1'b0; cpol = 1'b0; cpha = 1'b0;
        tx_scale = 16'h0002; rx_scale = 16'h0002;
        repeat (3) @(negedge clk);
        exp_iv[0] = 4;
        exp_iv[1] = after_rise ? 2 : 4;
        exp_iv[2] = 2;
        run = 1'b1; prev = sck; armed = 1'b0; iv_n = 0; last_t = 0; c = 0; seen_fall = 0;
        while (iv_n < 3 && c < 200) begin
            @(negedge clk);
            c++;
            if (sck != prev) begin
                if (armed) begin
                    chk(c - last_t == exp_iv[iv_n], "R8", c - last_t, exp_iv[iv_n]);
                    iv_n++;
                end else if ((after_rise && sck) || (!after_rise && !sck)) begin
                    tx_scale = 16'h0001; rx_scale = 16'h0001;
                    armed = 1'b1;
                end
                last_t = c;
            end
            prev = sck;
        end
        chk(iv_n == 3, "R8", iv_n, 3);
        run = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(sck == 1'b1 && !launch && !sample, "R1", int'(sck), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sck == 1'b1, "R1", int'(sck), 1);

        for (int m = 0; m < 4; m++) begin
            for (int code = 0; code <= 4; code++) begin
                run_case(16'(code), 16'(code), m[1], m[0], 2 << code, 2 << code, 3, "R2");
                run_case(16'h1F00 | 16'(code), 16'h1F00 | 16'(code), m[1], m[0],
                         64 << code, 64 << code, 2, "R3");
            end
            run_case(16'h0007, 16'h0007, m[1], m[0], 1, 1, 4, "R4");
        end

        run_case(16'h0001, 16'h0003, 1'b0, 1'b1, 4, 16, 12, "R7");
        run_case(16'h0003, 16'h0000, 1'b1, 1'b1, 16, 2, 3, "R7");
        run_case(16'h0000, 16'h0007, 1'b0, 1'b0, 2, 1, 4, "R7");

        run_case(16'hFEFD, 16'hFEFD, 1'b0, 1'b0, 32, 32, 3, "R9");
        run_case(16'h0006, 16'h0006, 1'b1, 1'b0, 32, 32, 3, "R9");
        run_case(16'h1F07, 16'h1F07, 1'b0, 1'b1, 32, 32, 3, "R9");
        run_case(16'hE000, 16'hE000, 1'b1, 1'b1, 2, 2, 3, "R9");

        change_case(1'b1);
        change_case(1'b0);

        summary();
        $finish;
    end
endmodule